// File: doc/BRIEF.md
# 1-Wire Reset and Presence Sequencer

This block runs the bus reset and presence-detect handshake of a 1-Wire master when commanded, then sums up how the bus reacted in one response byte. A start pulse, which also carries a two-bit speed code, makes it pull the bus low for the reset-low time. After that it releases the bus and takes samples at set points on the synchronized bus input. All phase lengths are clock-tick counts. Each speed class has its own set.

The first sample is taken a short time after release. Its job is to tell a shorted bus, or a slave holding the line low to signal an alarm, apart from a normal bus. When that sample reads low, a long re-test delay follows. A second low reading means the bus is shorted, and that is reported at once. A high reading means an alarming presence, which is reported after the fill delay. On a normal bus the block waits the presence offset, samples for a presence pulse, then waits the fill delay before it responds. The response byte also holds a three-bit revision value and a flag that shows programming voltage is present.

Top module: `owire_rst_seq`

## Requirements
- R1: After reset `bus_pull`, `busy` and `resp_valid` are 0 and `speed_q` is 00.
- R2: Take the cycle in which `cmd_go` is sampled high while idle. From the next cycle on, `bus_pull` is high for exactly the reset-low tick count of the selected speed, and is low at every other time.
- R3: If the first sample reads high and the presence sample reads low, the response code in bits 1:0 is 01. `resp_valid` rises reset-low + short-offset + presence-offset + fill ticks after the capture edge.
- R4: If the first sample reads high and the presence sample reads high, the code is 11 and the timing is the same as in R3.
- R5: If the first sample and the re-test sample both read low, the code is 00. `resp_valid` rises reset-low + short-offset + re-test ticks after the capture edge. There is no fill wait.
- R6: If the first sample reads low and the re-test reads high, the code is 10. `resp_valid` rises reset-low + short-offset + re-test + fill ticks after the capture edge, and no presence sample is taken.
- R7: In the response byte, bits 4:2 equal `chip_rev`, bit 5 equals `vpp_ok` and bits 7:6 are 11.
- R8: The speed code is captured with `cmd_go` and stays on `speed_q` until the next start. Codes 00 and 01 use the regular tick set, and 10 and 11 use the overdrive set. The short test, with the same re-test delay, runs at every speed.
- R9: `resp_valid` is a one-cycle pulse. `busy` is high from the capture edge until the edge that raises `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Start a reset sequence (used while idle) |
| cmd_speed | input | 2 | Speed code captured with the start |
| chip_rev | input | 3 | Revision value placed in the response |
| vpp_ok | input | 1 | Programming voltage present |
| bus_in | input | 1 | Raw bus level, asynchronous |
| bus_pull | output | 1 | Bus pull-down enable |
| busy | output | 1 | Sequence in progress |
| resp_valid | output | 1 | Response byte strobe |
| resp_byte | output | 8 | Response byte |
| speed_q | output | 2 | Persisted speed code |

## Verification
On a shorted bus, the re-test sample and the response strobe are produced by the same clock edge. The presence path instead always has a fill phase between its last sample and the response. The bench triggers the short case by holding the bus low through both sample windows at every speed code. It judges the result by the exact cycle in which the strobe appears against the computed sum of phase lengths, and by the code value. A second overlap, where the speed capture and the first timer load happen on one edge, is judged by the reset-low length seen on `bus_pull` when the previous run used a different speed.

// File: rtl/owr_pkg.sv
package owr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_SI, ST_PDT, ST_RT, ST_FILL
  } owr_state_e;

  typedef enum logic [1:0] {
    RX_SHORT = 2'b00,
    RX_PRES  = 2'b01,
    RX_ALARM = 2'b10,
    RX_NONE  = 2'b11
  } owr_rx_e;

  // response byte layout: class pattern, vpp flag, revision, reaction code
  function automatic logic [7:0] owr_pack(owr_rx_e code, logic [2:0] rev, logic vpp);
    return {2'b11, vpp, rev, code};
  endfunction

  // speed codes with the upper bit set use the overdrive tick set
  function automatic logic owr_is_od(logic [1:0] spd);
    return spd[1];
  endfunction
endpackage

// File: rtl/owr_sync.sv
module owr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/owr_timer.sv
module owr_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] value,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] ld_val;

  // a zero length is stretched to one tick so every phase ends
  assign ld_val = (value == '0) ? TW'(1) : value;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= ld_val;
    else if (cnt != '0)     cnt <= cnt - TW'(1);

  assign expire = (cnt == TW'(1));

  // R2
  timer_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt > TW'(1)) |=> (cnt == $past(cnt) - TW'(1)));
endmodule

// File: rtl/owr_timing.sv
module owr_timing #(
  parameter int TW       = 20,
  parameter int RSTL_REG = 102400,
  parameter int SI_REG   = 1600,
  parameter int PDT_REG  = 12000,
  parameter int FILL_REG = 24000,
  parameter int RSTL_OD  = 12800,
  parameter int SI_OD    = 400,
  parameter int PDT_OD   = 1600,
  parameter int FILL_OD  = 3200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [1:0]    spd_in,
  output logic [1:0]    speed_q,
  output logic [TW-1:0] t_rstl,
  output logic [TW-1:0] t_si,
  output logic [TW-1:0] t_pdt,
  output logic [TW-1:0] t_fill
);
  import owr_pkg::*;

  logic [1:0] sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   speed_q <= 2'b00;
    else if (cap) speed_q <= spd_in;

  // the new code steers the very load made on the capture edge
  assign sel = cap ? spd_in : speed_q;

  always_comb begin
    if (owr_is_od(sel)) begin
      t_rstl = TW'(RSTL_OD);
      t_si   = TW'(SI_OD);
      t_pdt  = TW'(PDT_OD);
      t_fill = TW'(FILL_OD);
    end else begin
      t_rstl = TW'(RSTL_REG);
      t_si   = TW'(SI_REG);
      t_pdt  = TW'(PDT_REG);
      t_fill = TW'(FILL_REG);
    end
  end
endmodule

// File: rtl/owire_rst_seq.sv
module owire_rst_seq #(
  parameter int TW        = 20,
  parameter int RSTL_REG  = 102400,
  parameter int SI_REG    = 1600,
  parameter int PDT_REG   = 12000,
  parameter int FILL_REG  = 24000,
  parameter int RSTL_OD   = 12800,
  parameter int SI_OD     = 400,
  parameter int PDT_OD    = 1600,
  parameter int FILL_OD   = 3200,
  parameter int RETEST    = 819200,
  parameter int SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic [1:0] cmd_speed,
  input  logic [2:0] chip_rev,
  input  logic       vpp_ok,
  input  logic       bus_in,
  output logic       bus_pull,
  output logic       busy,
  output logic       resp_valid,
  output logic [7:0] resp_byte,
  output logic [1:0] speed_q
);
  import owr_pkg::*;

  localparam logic [TW-1:0] T_RT = TW'(RETEST);

  owr_state_e    state;
  owr_rx_e       code_q;
  logic          bus_s, expire, tload, cap;
  logic [TW-1:0] tval, t_rstl, t_si, t_pdt, t_fill;

  // named events for the checks
  logic si_sample, pdt_sample, rt_sample, fill_done;

  assign cap        = (state == ST_IDLE) && cmd_go;
  assign si_sample  = (state == ST_SI)   && expire;
  assign pdt_sample = (state == ST_PDT)  && expire;
  assign rt_sample  = (state == ST_RT)   && expire;
  assign fill_done  = (state == ST_FILL) && expire;

  owr_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(bus_in), .d_out(bus_s));

  owr_timing #(
    .TW(TW), .RSTL_REG(RSTL_REG), .SI_REG(SI_REG), .PDT_REG(PDT_REG),
    .FILL_REG(FILL_REG), .RSTL_OD(RSTL_OD), .SI_OD(SI_OD), .PDT_OD(PDT_OD),
    .FILL_OD(FILL_OD)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .cap(cap), .spd_in(cmd_speed), .speed_q(speed_q),
    .t_rstl(t_rstl), .t_si(t_si), .t_pdt(t_pdt), .t_fill(t_fill));

  owr_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .value(tval), .expire(expire));

  always_comb begin
    tload = 1'b0;
    tval  = '0;
    if (cap) begin
      tload = 1'b1; tval = t_rstl;
    end else if ((state == ST_LOW) && expire) begin
      tload = 1'b1; tval = t_si;
    end else if (si_sample) begin
      tload = 1'b1; tval = bus_s ? t_pdt : T_RT;
    end else if (pdt_sample || (rt_sample && bus_s)) begin
      tload = 1'b1; tval = t_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      code_q     <= RX_NONE;
      resp_valid <= 1'b0;
      resp_byte  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_go) state <= ST_LOW;
        ST_LOW:  if (expire) state <= ST_SI;
        ST_SI:   if (expire) state <= bus_s ? ST_PDT : ST_RT;
        ST_PDT:  if (expire) begin
          code_q <= bus_s ? RX_NONE : RX_PRES;
          state  <= ST_FILL;
        end
        ST_RT:   if (expire) begin
          if (bus_s) begin
            code_q <= RX_ALARM;
            state  <= ST_FILL;
          end else begin
            resp_valid <= 1'b1;
            resp_byte  <= owr_pack(RX_SHORT, chip_rev, vpp_ok);
            state      <= ST_IDLE;
          end
        end
        ST_FILL: if (expire) begin
          resp_valid <= 1'b1;
          resp_byte  <= owr_pack(code_q, chip_rev, vpp_ok);
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_pull = (state == ST_LOW);
  assign busy     = (state != ST_IDLE);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_pull);
  // R2
  go_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy) |=> bus_pull);
  // R3
  pres_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdt_sample |=> (!resp_valid && busy));
  // R5
  short_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sample && !bus_s) |=> (resp_valid && resp_byte[1:0] == 2'b00));
  // R7
  class_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_byte[7:6] == 2'b11));
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

// File: tb/sim_owire_rst_seq.sv
module sim_owire_rst_seq;
  localparam int RSTL_R = 12, SI_R = 4, PDT_R = 6, FILL_R = 5;
  localparam int RSTL_O = 7,  SI_O = 3, PDT_O = 4, FILL_O = 3;
  localparam int RT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 1'b0, vpp_ok = 1'b0, bus_in = 1'b1;
  logic [1:0] cmd_speed = 2'b00;
  logic [2:0] chip_rev = 3'd0;
  logic bus_pull, busy, resp_valid;
  logic [7:0] resp_byte;
  logic [1:0] speed_q;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owire_rst_seq #(
    .TW(10), .RSTL_REG(RSTL_R), .SI_REG(SI_R), .PDT_REG(PDT_R), .FILL_REG(FILL_R),
    .RSTL_OD(RSTL_O), .SI_OD(SI_O), .PDT_OD(PDT_O), .FILL_OD(FILL_O),
    .RETEST(RT), .SYNC_STGS(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_speed(cmd_speed),
    .chip_rev(chip_rev), .vpp_ok(vpp_ok), .bus_in(bus_in), .bus_pull(bus_pull),
    .busy(busy), .resp_valid(resp_valid), .resp_byte(resp_byte), .speed_q(speed_q));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(input logic [1:0] spd, input bit lsi, input bit lpd,
                     input bit lrt, input logic [2:0] rev, input bit vpp);
    int rl, si, pd, fl, tot, n, perr, expc;
    bit od;
    od = spd[1];
    rl = od ? RSTL_O : RSTL_R;  si = od ? SI_O : SI_R;
    pd = od ? PDT_O  : PDT_R;   fl = od ? FILL_O : FILL_R;
    if (lsi) begin
      tot = rl + si + pd + fl; expc = lpd ? 3 : 1;
    end else if (lrt) begin
      tot = rl + si + RT + fl; expc = 2;
    end else begin
      tot = rl + si + RT;      expc = 0;
    end
    @(negedge clk);
    cmd_speed = spd; cmd_go = 1'b1; chip_rev = rev; vpp_ok = vpp; bus_in = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0; n = 1; perr = 0;
    forever begin
      if (bus_pull != (n <= rl)) perr++;
      if (n < rl)           bus_in = 1'b0;
      else if (n < rl + si) bus_in = lsi;
      else                  bus_in = lsi ? lpd : lrt;
      if (resp_valid || n > 2000) break;
      @(negedge clk);
      n++;
    end
    // R2: pull-down length per speed, R8 overdrive/regular selection
    check("R2 pull window", perr, 0);
    case (expc)
      0: begin check("R5 short latency", n, tot + 1); check("R5 short code", resp_byte[1:0], 0); end
      1: begin check("R3 presence latency", n, tot + 1); check("R3 presence code", resp_byte[1:0], 1); end
      2: begin check("R6 alarm latency", n, tot + 1); check("R6 alarm code", resp_byte[1:0], 2); end
      default: begin check("R4 none latency", n, tot + 1); check("R4 none code", resp_byte[1:0], 3); end
    endcase
    check("R7 upper fields", resp_byte[7:2], {2'b11, vpp, rev});
    check("R8 speed kept", speed_q, spd);
    check("R9 busy low at response", busy, 0);
    bus_in = 1'b1;
    @(negedge clk);
    check("R9 single pulse", resp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pull", bus_pull, 0);
    check("R1 busy", busy, 0);
    check("R1 valid", resp_valid, 0);
    check("R1 speed", speed_q, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        run(2'(s), p < 2, p == 1, p == 3, 3'(s * 2 + p), (s + p) % 2 == 1);
      end
    end
    // alternate speeds back to back so the capture edge picks the new set
    run(2'b10, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1);
    run(2'b00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    run(2'b11, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1);
    run(2'b01, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule